// File: doc/BRIEF.md
# Polar Sigma-Delta Single-Bit Synthesizer

The block turns a frequency control word into a one-bit stream. The stream approximates a sinusoid at the programmed frequency, and its spectrum near the carrier stays free of spurs. A phase accumulator steps by the control word on every clock. The phase drives a computed cosine. Scaled noise is added to that cosine, and the sum is reduced to its sign. Two feedback loops then correlate the output bit with the unshifted reference.

The product with the reference cosine is compared with a target amplitude and integrated. A gain turns that integral into the noise standard deviation, and more noise gives a smaller fundamental in the ±1 output. The product with the reference sine is integrated and scaled by a second gain. The result is a phase offset added ahead of the quantizer.

Both integrators take their input from the same registered bit on the same edge, and their new values act on the next sample. The dither is the sum of four independent pseudo-random uniform samples, scaled by the amplitude loop output. The scale is clamped to a range that never goes below zero.

Top module: `psd_synth`

## Requirements
- R1: While `rst_n` is low, `bit_out` is 0. The first sample after release is taken at phase 0.
- R2: A `bit_out` of 1 stands for +1 and 0 for −1. With `ka` = 0 and `kp` = 0, sample j (j = 0 for the first clock after reset) is 1 exactly when bits [14:13] of (j·`fcw`) mod 2^15 are 00 or 11. The fundamental of this stream then has an amplitude of about 4/π.
- R3: At each clock edge the phase advances by the `fcw` value present at that edge. A change of `fcw` therefore continues from the current phase, with no jump.
- R4: `ka` and `kp` are unsigned, in units of 1/256. `amp_target` is unsigned with 14 fractional bits. With `ka` = 64, `kp` = 32 and `amp_target` = 8192 (0.5), the measured fundamental amplitude settles within 0.1 of 0.5.
- R5: With the same gains and `amp_target` = 16384 (1.0), the fundamental amplitude settles within 0.1 of 1.0.
- R6: The dither scale never goes negative. If `amp_target` exceeds anything the output can reach (for example 16'hFFFF), the stream equals the undithered stream of R2 exactly, even with `ka` nonzero.
- R7: With the phase loop closed (`kp` = 32), the correlation of the output with the reference sine stays within 0.08 of zero. The phase correction is clamped to at most a quarter cycle either way.
- R8: Both loop integrators saturate at their signed limits and never wrap.
- R9: When `ka` is 0 the added dither is exactly zero. The pseudo-random generators never lock up in the all-zero state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fcw | input | 15 | Frequency control word, phase step per clock |
| ka | input | 8 | Amplitude loop gain, units of 1/256 |
| kp | input | 8 | Phase loop gain, units of 1/256 |
| amp_target | input | 16 | Desired fundamental amplitude, 14 fractional bits |
| bit_out | output | 1 | Synthesized bit stream (1 = +1, 0 = −1) |

## Verification
The bench sweeps many control words with both loops off and compares every bit with the quadrant of the phase. This catches an off-by-one sample alignment, a cosine sign error at the quarter points, and an accumulator that restarts when the word changes. It drives an unreachable amplitude target with the amplitude gain on. A scale clamp that lets the value go negative, or an integrator that wraps, would then inject noise and break the exact match. In the closed-loop runs the bench measures the in-phase and quadrature correlations with its own sinusoid. An inverted loop sign, or a missing phase clamp, would leave the amplitude off target or push the quadrature term far from zero.

// File: rtl/psd_pkg.sv
`timescale 1ns/1ps
package psd_pkg;

   // Parabolic cosine sampled at the centre of table slot idx (0 .. 2^tw-1).
   // Result is scaled by 2^(2*(tw-1)) and is never zero.
   function automatic int wave_at(input int idx, input int tw);
      int half;
      int v;
      int d;
      int r;
      int mag;
      half = 1 << (tw - 1);
      v    = 2 * idx + 1;
      d    = (v < (1 << tw)) ? v : ((1 << (tw + 1)) - v);
      r    = half - d;
      mag  = (r < 0) ? -r : r;
      return r * (2 * half - mag);
   endfunction

endpackage

// File: rtl/psd_integ.sv
`timescale 1ns/1ps
module psd_integ #(
   parameter int IW = 24,
   parameter int DW = 18
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 en,
   input  logic signed [DW-1:0] din,
   output logic signed [IW-1:0] acc
);
   localparam logic signed [IW:0] MAXV = (IW+1)'({1'b0, {(IW-1){1'b1}}});
   localparam logic signed [IW:0] MINV = -MAXV;

   logic signed [IW:0] nxt;

   always_comb begin
      nxt = (IW+1)'(acc) + (IW+1)'(din);
      if (nxt > MAXV)      nxt = MAXV;
      else if (nxt < MINV) nxt = MINV;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  acc <= '0;
      else if (en) acc <= nxt[IW-1:0];
   end

   if (DW >= IW) begin : g_bad_width
      $error("psd_integ: input width must be below accumulator width");
   end

   AST_INTEG_NO_WRAP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (en && din >= 0) |=> (acc >= $past(acc))) else $error("integrator wrapped upward"); // R8
   AST_INTEG_NO_WRAP_DN: assert property (@(posedge clk) disable iff (!rst_n)
      (en && din <= 0) |=> (acc <= $past(acc))) else $error("integrator wrapped downward"); // R8
endmodule

// File: rtl/psd_dither.sv
`timescale 1ns/1ps
module psd_dither #(
   parameter int              NDITH = 4,
   parameter int              LW    = 24,
   parameter logic [LW-1:0]   TAPS  = 24'hE10000,
   parameter int              UB    = 9,
   parameter int              SW    = 8,
   parameter int              SF    = 6,
   parameter int              CF    = 14,
   parameter int              OW    = 21
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [SW-1:0]        scale,
   output logic signed [OW-1:0] u
);
   localparam int SUMW = UB + $clog2(NDITH) + 1;
   localparam int DSH  = UB - 1 + SF - CF;

   logic [NDITH-1:0][UB-1:0] smp;
   logic signed [SUMW-1:0]   sum;
   logic signed [OW-1:0]     prod;

   for (genvar g = 0; g < NDITH; g++) begin : g_src
      localparam logic [LW-1:0] SEED = LW'((g + 1) * 40503 + 4951) | LW'(1);
      logic [LW-1:0] q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= SEED;
         else        q <= {1'b0, q[LW-1:1]} ^ (q[0] ? TAPS : '0);
      end
      assign smp[g] = q[UB-1:0];
      AST_LFSR_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
         q != '0) else $error("dither generator locked at zero"); // R9
   end

   always_comb begin
      sum = '0;
      for (int i = 0; i < NDITH; i++) sum = sum + SUMW'(signed'(smp[i]));
      prod = OW'(sum) * OW'(signed'({1'b0, scale}));
      u    = prod >>> DSH;
   end

   if (DSH < 0) begin : g_bad_frac
      $error("psd_dither: dither fraction bits too few for the reference");
   end
   if (OW < SUMW + SW + 1) begin : g_bad_ow
      $error("psd_dither: output width too small");
   end
endmodule

// File: rtl/psd_synth.sv
`timescale 1ns/1ps
module psd_synth #(
   parameter int PW    = 15,
   parameter int TW    = 8,
   parameter int GW    = 8,
   parameter int GF    = 8,
   parameter int IW    = 24,
   parameter int SW    = 8,
   parameter int SF    = 6,
   parameter int SMAX  = 255,
   parameter int UB    = 9,
   parameter int NDITH = 4,
   parameter int LW    = 24
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [PW-1:0]           fcw,
   input  logic [GW-1:0]           ka,
   input  logic [GW-1:0]           kp,
   input  logic [2*(TW-1)+1:0]     amp_target,
   output logic                    bit_out
);
   localparam int CF  = 2 * (TW - 1);
   localparam int CWS = CF + 2;
   localparam int AW  = CF + 2;
   localparam int DW  = CF + 4;
   localparam int OW  = UB + $clog2(NDITH) + 1 + SW + 1;
   localparam int PRW = IW + GW + 1;
   localparam int KSH = GF + CF - SF + 1;
   localparam int PSH = GF + CF - PW + 3;
   localparam logic signed [PRW-1:0] QTR  = PRW'(1 << (PW - 2));
   localparam logic signed [PRW-1:0] SLIM = PRW'(SMAX);
   localparam logic [TW-1:0]         QOFS = TW'(1 << (TW - 2));

   logic [PW-1:0]           acc_q;
   logic [PW-1:0]           pos;
   logic [PW-1:0]           phi;
   logic [TW-1:0]           q_idx;
   logic [TW-1:0]           idx_d;
   logic [TW-1:0]           s_idx;
   logic                    y_q;
   logic                    v_q;
   logic signed [CWS-1:0]   c_q;
   logic signed [CWS-1:0]   c_r;
   logic signed [CWS-1:0]   s_r;
   logic signed [OW:0]      qsum;
   logic signed [OW-1:0]    u;
   logic [SW-1:0]           scale;
   logic signed [DW-1:0]    yc_r;
   logic signed [DW-1:0]    da;
   logic signed [DW-1:0]    dp;
   logic signed [IW-1:0]    ia;
   logic signed [IW-1:0]    ip;
   logic signed [PRW-1:0]   pa;
   logic signed [PRW-1:0]   pa_s;
   logic signed [PRW-1:0]   pp;
   logic signed [PRW-1:0]   pp_s;

   // quantizer path: corrected phase -> cosine -> plus dither -> sign
   assign pos   = acc_q + phi;
   assign q_idx = pos[PW-1 -: TW];
   assign s_idx = idx_d - QOFS;

   always_comb begin
      c_q  = CWS'(psd_pkg::wave_at(int'(q_idx), TW));
      c_r  = CWS'(psd_pkg::wave_at(int'(idx_d), TW));
      s_r  = CWS'(psd_pkg::wave_at(int'(s_idx), TW));
      qsum = (OW+1)'(c_q) + (OW+1)'(u);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         idx_d <= '0;
         y_q   <= 1'b0;
         v_q   <= 1'b0;
      end else begin
         acc_q <= acc_q + fcw;
         idx_d <= acc_q[PW-1 -: TW];
         y_q   <= (qsum >= 0);
         v_q   <= 1'b1;
      end
   end

   assign bit_out = y_q;

   // loop inputs: correlations of the registered bit with the reference
   always_comb begin
      yc_r = y_q ? DW'(c_r) : -DW'(c_r);
      da   = (yc_r <<< 1) - signed'(DW'(amp_target));
      dp   = y_q ? DW'(s_r) : -DW'(s_r);
   end

   psd_integ #(.IW(IW), .DW(DW)) u_amp_int (
      .clk(clk), .rst_n(rst_n), .en(v_q), .din(da), .acc(ia));

   psd_integ #(.IW(IW), .DW(DW)) u_phs_int (
      .clk(clk), .rst_n(rst_n), .en(v_q), .din(dp), .acc(ip));

   // gain scaling and clamps
   always_comb begin
      pa   = PRW'(signed'({1'b0, ka})) * PRW'(ia);
      pa_s = pa >>> KSH;
      if (pa_s < 0)         scale = '0;
      else if (pa_s > SLIM) scale = SW'(SMAX);
      else                  scale = pa_s[SW-1:0];

      pp   = PRW'(signed'({1'b0, kp})) * PRW'(ip);
      pp_s = pp >>> PSH;
      if (pp_s > QTR)       phi = PW'(QTR);
      else if (pp_s < -QTR) phi = PW'(-QTR);
      else                  phi = pp_s[PW-1:0];
   end

   psd_dither #(
      .NDITH(NDITH), .LW(LW), .UB(UB), .SW(SW), .SF(SF), .CF(CF), .OW(OW)
   ) u_dither (
      .clk(clk), .rst_n(rst_n), .scale(scale), .u(u));

   // elaboration checks
   if (TW < 3 || TW > PW || TW > 15) begin : g_bad_tw
      $error("psd_synth: table index width out of range");
   end
   if (PSH < 0 || KSH < 0) begin : g_bad_shift
      $error("psd_synth: gain shift negative");
   end
   if (SMAX <= 0 || SMAX >= (1 << SW)) begin : g_bad_smax
      $error("psd_synth: scale limit does not fit");
   end
   if (PRW < PW + 2 || AW != CWS) begin : g_bad_prw
      $error("psd_synth: product width too small");
   end

   AST_RESET_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      !v_q |-> !bit_out) else $error("output not cleared by reset"); // R1
   AST_NO_DITHER_KA0: assert property (@(posedge clk) disable iff (!rst_n)
      (ka == '0) |-> (u == '0)) else $error("dither present with zero gain"); // R9
   AST_PLAIN_SIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (scale == '0 && phi == '0) |=>
      (bit_out == ~($past(acc_q[PW-1]) ^ $past(acc_q[PW-2]))))
      else $error("undithered sample has wrong sign"); // R6
endmodule

// File: tb/sim_psd_synth.sv
`timescale 1ns/1ps
module sim_psd_synth;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [14:0] fcw = '0;
   logic [7:0]  ka = '0;
   logic [7:0]  kp = '0;
   logic [15:0] amp_target = '0;
   logic        bit_out;

   int          nvec = 0;
   int          nbad = 0;
   bit          done = 1'b0;
   logic [14:0] accm = '0;

   always #5 clk = ~clk;

   psd_synth u0 (
      .clk(clk), .rst_n(rst_n), .fcw(fcw), .ka(ka), .kp(kp),
      .amp_target(amp_target), .bit_out(bit_out));

   task automatic start(input logic [14:0] f, input logic [7:0] a_g,
                        input logic [7:0] p_g, input logic [15:0] tgt);
      rst_n = 1'b0;
      fcw = f; ka = a_g; kp = p_g; amp_target = tgt;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         nvec++;
         if (bit_out !== 1'b0) begin
            nbad++;
            $display("FAIL R1: bit_out=%b during reset, expected 0", bit_out);
         end
      end
      rst_n = 1'b1;
      accm  = '0;
   endtask

   task automatic chk_bit(input string tag);
      logic e;
      @(negedge clk);
      e = ~(accm[14] ^ accm[13]);
      nvec++;
      if (bit_out !== e) begin
         nbad++;
         $display("FAIL %s: bit_out=%b expected %b at phase %0d", tag, bit_out, e, accm);
      end
      accm = accm + fcw;
   endtask

   task automatic measure(input int settle, input int n, output real a, output real b);
      real sc;
      real ss;
      real th;
      real y;
      sc = 0.0; ss = 0.0;
      for (int j = 0; j < settle + n; j++) begin
         @(negedge clk);
         if (j >= settle) begin
            th = 2.0 * 3.141592653589793 * real'(accm) / 32768.0;
            y  = bit_out ? 1.0 : -1.0;
            sc = sc + y * $cos(th);
            ss = ss + y * $sin(th);
         end
         accm = accm + fcw;
      end
      a = 2.0 * sc / real'(n);
      b = 2.0 * ss / real'(n);
   endtask

   task automatic chk_real(input string tag, input real act, input real exp_v, input real tol);
      real d;
      d = act - exp_v;
      if (d < 0.0) d = -d;
      nvec++;
      if (d > tol) begin
         nbad++;
         $display("FAIL %s: measured %f expected %f (tol %f)", tag, act, exp_v, tol);
      end
   endtask

   initial begin
      real a;
      real b;
      logic [14:0] f;

      // R2 R9: both loops off, sweep of control words
      for (int i = 0; i < 48; i++) begin
         f = 15'((i * 683 + 1) % 16384);
         if (i == 47) f = 15'd8192;
         if (i == 46) f = 15'd4096;
         if (i == 45) f = 15'd16383;
         start(f, 8'd0, 8'd0, 16'd8192);
         for (int j = 0; j < 200; j++) chk_bit("R2 R9");
      end

      // R3: control word changes keep phase continuity
      start(15'd1000, 8'd0, 8'd0, 16'd0);
      for (int j = 0; j < 150; j++) chk_bit("R3");
      fcw = 15'd4321;
      for (int j = 0; j < 150; j++) chk_bit("R3");
      fcw = 15'd0;
      for (int j = 0; j < 40; j++) chk_bit("R3");
      fcw = 15'd12000;
      for (int j = 0; j < 80; j++) chk_bit("R3");

      // R6 R8: unreachable target keeps scale at zero despite nonzero gain
      start(15'd4321, 8'd64, 8'd0, 16'hFFFF);
      for (int j = 0; j < 3000; j++) chk_bit("R6 R8");

      // R2: undithered fundamental amplitude close to 4/pi
      start(15'd4321, 8'd0, 8'd0, 16'd0);
      measure(0, 8000, a, b);
      chk_real("R2 amplitude", a, 4.0 / 3.141592653589793, 0.04);

      // R4 R7: target 0.5
      start(15'd4321, 8'd64, 8'd32, 16'd8192);
      measure(4000, 30000, a, b);
      chk_real("R4", a, 0.5, 0.1);
      chk_real("R7", b, 0.0, 0.08);

      // R5 R7: target 1.0
      start(15'd4321, 8'd64, 8'd32, 16'd16384);
      measure(4000, 30000, a, b);
      chk_real("R5", a, 1.0, 0.1);
      chk_real("R7", b, 0.0, 0.08);

      // R7: phase loop alone
      start(15'd4321, 8'd0, 8'd32, 16'd0);
      measure(2000, 12000, a, b);
      chk_real("R7 phase-only", b, 0.0, 0.08);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
   end

   initial begin
      #1950000;
      if (!done) begin
         nvec++;
         nbad++;
         $display("FAIL watchdog: run still busy, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
         $finish;
      end
   end
endmodule